// File: doc/BRIEF.md
# Cursor Register Port

This block is the host-side register port of a hardware cursor. The host first loads an 11-bit address pointer. It then issues byte reads and writes, and the pointer steps forward by one after every data access. Through this port the host reaches three things: four position bytes that form a signed 16-bit X and a signed 16-bit Y coordinate, a small control register that selects the cursor mode, enable and interlace, and a 1024-byte cursor image store. The display side reads the image store through its own read port.

Position bytes are not sent to the display one at a time. A four-state sequencer accepts them only in the order X-low, X-high, Y-low, Y-high. When the last byte of a complete ordered run arrives, the sequencer commits the pair into the pending coordinates. At each vertical-retrace pulse the display-side coordinates copy the pending pair, so the cursor moves at most once per frame and never shows a half-written position.

Sequencer states: SEQ_WAIT_XL, SEQ_WAIT_XH, SEQ_WAIT_YL and SEQ_WAIT_YH. Each state names the byte it expects next. An in-order byte advances the sequencer one state. The Y-high byte in SEQ_WAIT_YH commits and returns to SEQ_WAIT_XL. An X-low byte that arrives in any other state restarts the sequencer into SEQ_WAIT_XH. Any other out-of-order position byte drops it back to SEQ_WAIT_XL.

Top module: `cur_regport`

## Requirements
- R1: After reset the pointer is 000h, the sequencer waits for X-low, the pending and display coordinates are zero, and the mode, enable and interlace outputs are zero.
- R2: A cycle with addr_wr high loads the pointer from addr_in, and any data strobe in that cycle is ignored. Every other cycle with data_wr or data_rd high adds one to the pointer, and the pointer wraps from 7FFh to 000h.
- R3: The position bytes are at 200h (X low), 201h (X high), 202h (Y low) and 203h (Y high). A coordinate is {high, low} in two's complement. The pending X and Y both change only when 203h is written immediately after in-order writes to 200h, 201h and 202h. Accesses to other addresses between these writes do not break the order.
- R4: An out-of-order write to 200h–203h does not commit anything. A write to 200h starts a new run with that byte, and a write to 201h–203h returns the sequencer to waiting for X-low.
- R5: A read of 200h–203h returns the matching byte of the pending coordinates on rdata one cycle after the strobe, and it does not disturb the sequencer. rdata holds its value until the next read.
- R6: cur_x and cur_y change only in a cycle with vretrace high, and then they take the pending pair. If a commit happens in that same cycle, they take the newly committed pair.
- R7: Address 204h is the control register: bit 0 and bit 1 give cur_mode, bit 2 gives cur_en and bit 3 gives cur_ilace. Reading it returns bits 7:4 as zero.
- R8: Addresses 400h–7FFh hold image byte (address − 400h). Host reads return the stored byte, and img_rdata returns the byte at img_raddr one cycle later.
- R9: Writes to any address outside 200h–204h and 400h–7FFh are ignored, and reads of such an address return 00h.
- R10: When data_wr and data_rd are both high in one cycle, only the write takes place, and the pointer advances once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_wr | input | 1 | Load the address pointer |
| addr_in | input | 11 | New pointer value |
| data_wr | input | 1 | Byte write at the pointer |
| data_rd | input | 1 | Byte read at the pointer |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid one cycle after data_rd |
| vretrace | input | 1 | One-cycle vertical-retrace pulse |
| img_raddr | input | 10 | Display-side image byte index |
| img_rdata | output | 8 | Image byte at img_raddr, one cycle later |
| cur_x | output | 16 | Display X coordinate, signed |
| cur_y | output | 16 | Display Y coordinate, signed |
| cur_mode | output | 2 | Cursor mode select |
| cur_en | output | 1 | Cursor enable |
| cur_ilace | output | 1 | Interlace select |

## Verification
Two functions can fall in the same cycle: the commit of a position pair by the Y-high write, and the vertical-retrace pulse that loads the display coordinates. The bench lines the two up deliberately. It raises vretrace in the same cycle as the 203h write that completes an ordered run, and then expects cur_x and cur_y to show the new pair at once, not the older pending pair. The random phase also fires retrace pulses between partial runs and broken runs. There the display must keep the last complete pair.

// File: rtl/cur_regport_pkg.sv
package cur_regport_pkg;
    localparam int ADDR_W      = 11;
    localparam int IMG_SEL_BIT = 10;
    localparam logic [ADDR_W-1:0] A_X_LO = 11'h200;
    localparam logic [ADDR_W-1:0] A_CTRL = 11'h204;

    typedef enum logic [1:0] {
        SEQ_WAIT_XL,
        SEQ_WAIT_XH,
        SEQ_WAIT_YL,
        SEQ_WAIT_YH
    } seq_state_t;

    typedef enum logic [1:0] {
        SRC_ZERO,
        SRC_REG,
        SRC_IMG
    } rd_src_t;
endpackage

// File: rtl/cur_addr_ptr.sv
module cur_addr_ptr #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (load)
            ptr <= load_val;
        else if (step)
            ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/cur_coord_seq.sv
module cur_coord_seq
    import cur_regport_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int COORD_W = 2 * BYTE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         sel_idx,
    input  logic [BYTE_W-1:0]  wdata,
    input  logic               vretrace,
    output logic [COORD_W-1:0] pend_x,
    output logic [COORD_W-1:0] pend_y,
    output logic [COORD_W-1:0] disp_x,
    output logic [COORD_W-1:0] disp_y,
    output logic               commit
);
    seq_state_t        state_q, state_d;
    logic [1:0]        exp_idx;
    logic              in_order;
    logic [BYTE_W-1:0] xl_q, xh_q, yl_q;
    logic [COORD_W-1:0] new_x, new_y;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SEQ_WAIT_XL;
        else
            state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        unique case (state_q)
            SEQ_WAIT_XL: exp_idx = 2'd0;
            SEQ_WAIT_XH: exp_idx = 2'd1;
            SEQ_WAIT_YL: exp_idx = 2'd2;
            SEQ_WAIT_YH: exp_idx = 2'd3;
        endcase
        in_order = wr_en && (sel_idx == exp_idx);
        commit   = in_order && (state_q == SEQ_WAIT_YH);
        state_d  = state_q;
        if (wr_en) begin
            if (in_order) begin
                unique case (state_q)
                    SEQ_WAIT_XL: state_d = SEQ_WAIT_XH;
                    SEQ_WAIT_XH: state_d = SEQ_WAIT_YL;
                    SEQ_WAIT_YL: state_d = SEQ_WAIT_YH;
                    SEQ_WAIT_YH: state_d = SEQ_WAIT_XL;
                endcase
            end else if (sel_idx == 2'd0) begin
                state_d = SEQ_WAIT_XH;
            end else begin
                state_d = SEQ_WAIT_XL;
            end
        end
    end

    assign new_x = {xh_q, xl_q};
    assign new_y = {wdata, yl_q};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xl_q   <= '0;
            xh_q   <= '0;
            yl_q   <= '0;
            pend_x <= '0;
            pend_y <= '0;
            disp_x <= '0;
            disp_y <= '0;
        end else begin
            if (wr_en && sel_idx == 2'd0)
                xl_q <= wdata;
            if (in_order && sel_idx == 2'd1)
                xh_q <= wdata;
            if (in_order && sel_idx == 2'd2)
                yl_q <= wdata;
            if (commit) begin
                pend_x <= new_x;
                pend_y <= new_y;
            end
            if (vretrace) begin
                disp_x <= commit ? new_x : pend_x;
                disp_y <= commit ? new_y : pend_y;
            end
        end
    end
endmodule

// File: rtl/cur_image_ram.sv
module cur_image_ram #(
    parameter int DEPTH  = 1024,
    parameter int BYTE_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              re,
    input  logic [IDX_W-1:0]  raddr_a,
    output logic [BYTE_W-1:0] rdata_a,
    input  logic [IDX_W-1:0]  raddr_b,
    output logic [BYTE_W-1:0] rdata_b
);
    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
        if (re)
            rdata_a <= mem[raddr_a];
        rdata_b <= mem[raddr_b];
    end
endmodule

// File: rtl/cur_regport.sv
module cur_regport
    import cur_regport_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int IMG_DEPTH = 1024,
    localparam int COORD_W  = 2 * BYTE_W,
    localparam int IMG_W    = $clog2(IMG_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               addr_wr,
    input  logic [ADDR_W-1:0]  addr_in,
    input  logic               data_wr,
    input  logic               data_rd,
    input  logic [BYTE_W-1:0]  wdata,
    output logic [BYTE_W-1:0]  rdata,
    input  logic               vretrace,
    input  logic [IMG_W-1:0]   img_raddr,
    output logic [BYTE_W-1:0]  img_rdata,
    output logic [COORD_W-1:0] cur_x,
    output logic [COORD_W-1:0] cur_y,
    output logic [1:0]         cur_mode,
    output logic               cur_en,
    output logic               cur_ilace
);
    logic [ADDR_W-1:0]  ptr_q;
    logic               eff_wr, eff_rd, step;
    logic               in_coord, in_ctrl, in_img;
    logic               commit;
    logic [COORD_W-1:0] pend_x, pend_y;
    logic [3:0]         ctrl_q;
    logic [BYTE_W-1:0]  reg_byte, reg_rd_q, img_rd;
    rd_src_t            src_q;

    assign eff_wr = data_wr && !addr_wr;
    assign eff_rd = data_rd && !data_wr && !addr_wr;
    assign step   = (data_wr || data_rd) && !addr_wr;

    assign in_coord = (ptr_q[ADDR_W-1:2] == A_X_LO[ADDR_W-1:2]);
    assign in_ctrl  = (ptr_q == A_CTRL);
    assign in_img   = ptr_q[IMG_SEL_BIT];

    cur_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (addr_wr),
        .load_val (addr_in),
        .step     (step),
        .ptr      (ptr_q)
    );

    cur_coord_seq #(.BYTE_W(BYTE_W), .COORD_W(COORD_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (eff_wr && in_coord),
        .sel_idx  (ptr_q[1:0]),
        .wdata    (wdata),
        .vretrace (vretrace),
        .pend_x   (pend_x),
        .pend_y   (pend_y),
        .disp_x   (cur_x),
        .disp_y   (cur_y),
        .commit   (commit)
    );

    cur_image_ram #(.DEPTH(IMG_DEPTH), .BYTE_W(BYTE_W)) u_img (
        .clk     (clk),
        .we      (eff_wr && in_img),
        .waddr   (ptr_q[IMG_W-1:0]),
        .wdata   (wdata),
        .re      (eff_rd && in_img),
        .raddr_a (ptr_q[IMG_W-1:0]),
        .rdata_a (img_rd),
        .raddr_b (img_raddr),
        .rdata_b (img_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (eff_wr && in_ctrl)
            ctrl_q <= wdata[3:0];
    end

    assign cur_mode  = ctrl_q[1:0];
    assign cur_en    = ctrl_q[2];
    assign cur_ilace = ctrl_q[3];

    always_comb begin
        reg_byte = '0;
        if (in_ctrl)
            reg_byte = {{(BYTE_W-4){1'b0}}, ctrl_q};
        else if (in_coord) begin
            unique case (ptr_q[1:0])
                2'd0: reg_byte = pend_x[BYTE_W-1:0];
                2'd1: reg_byte = pend_x[COORD_W-1:BYTE_W];
                2'd2: reg_byte = pend_y[BYTE_W-1:0];
                2'd3: reg_byte = pend_y[COORD_W-1:BYTE_W];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q    <= SRC_ZERO;
            reg_rd_q <= '0;
        end else if (eff_rd) begin
            src_q    <= in_img ? SRC_IMG : SRC_REG;
            reg_rd_q <= reg_byte;
        end
    end

    always_comb begin
        unique case (src_q)
            SRC_IMG: rdata = img_rd;
            SRC_REG: rdata = reg_rd_q;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/cur_regport_chk.sv
module cur_regport_chk
    import cur_regport_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int COORD_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               addr_wr,
    input logic [ADDR_W-1:0]  addr_in,
    input logic               data_wr,
    input logic               data_rd,
    input logic               vretrace,
    input logic [ADDR_W-1:0]  ptr,
    input logic               commit,
    input logic [COORD_W-1:0] cur_x,
    input logic [COORD_W-1:0] cur_y,
    input logic [1:0]         cur_mode,
    input logic               cur_en,
    input logic               cur_ilace,
    input logic [BYTE_W-1:0]  rdata
);
    logic mapped;
    assign mapped = (ptr[ADDR_W-1:2] == A_X_LO[ADDR_W-1:2]) || (ptr == A_CTRL) || ptr[IMG_SEL_BIT];

    a_r2_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
        addr_wr |=> ptr == $past(addr_in));

    a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_wr && (data_wr || data_rd)) |=> ptr == $past(ptr) + 1'b1);

    a_r3_commit_at_yhi: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (data_wr && !addr_wr && ptr == A_X_LO + 11'd3));

    a_r6_disp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !vretrace |=> ($stable(cur_x) && $stable(cur_y)));

    a_r7_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_wr && !addr_wr && ptr == A_CTRL) |=> ($stable(cur_mode) && $stable(cur_en) && $stable(cur_ilace)));

    a_r5_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_rd && !data_wr && !addr_wr) |=> $stable(rdata));

    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !data_wr && !addr_wr && !mapped) |=> rdata == '0);
endmodule

bind cur_regport cur_regport_chk #(.BYTE_W(BYTE_W), .COORD_W(COORD_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_wr   (addr_wr),
    .addr_in   (addr_in),
    .data_wr   (data_wr),
    .data_rd   (data_rd),
    .vretrace  (vretrace),
    .ptr       (ptr_q),
    .commit    (commit),
    .cur_x     (cur_x),
    .cur_y     (cur_y),
    .cur_mode  (cur_mode),
    .cur_en    (cur_en),
    .cur_ilace (cur_ilace),
    .rdata     (rdata)
);

// File: tb/test_cur_regport.sv
`timescale 1ns/1ps
module test_cur_regport;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_wr = 1'b0;
    logic [10:0] addr_in = '0;
    logic        data_wr = 1'b0;
    logic        data_rd = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        vretrace = 1'b0;
    logic [9:0]  img_raddr = '0;
    logic [7:0]  img_rdata;
    logic [15:0] cur_x, cur_y;
    logic [1:0]  cur_mode;
    logic        cur_en, cur_ilace;

    always #2.5 clk = ~clk;

    cur_regport i_cur_regport (
        .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .addr_in(addr_in),
        .data_wr(data_wr), .data_rd(data_rd), .wdata(wdata), .rdata(rdata),
        .vretrace(vretrace), .img_raddr(img_raddr), .img_rdata(img_rdata),
        .cur_x(cur_x), .cur_y(cur_y), .cur_mode(cur_mode), .cur_en(cur_en),
        .cur_ilace(cur_ilace)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // reference model
    logic [10:0] mp = '0;
    int          ms = 0;
    logic [7:0]  sxl = '0, sxh = '0, syl = '0;
    logic [15:0] px = '0, py = '0, dx = '0, dy = '0;
    logic [3:0]  mctrl = '0;
    logic [7:0]  mimg [1024];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [10:0] a);
        if (a == 11'h200) return px[7:0];
        if (a == 11'h201) return px[15:8];
        if (a == 11'h202) return py[7:0];
        if (a == 11'h203) return py[15:8];
        if (a == 11'h204) return {4'h0, mctrl};
        if (a[10])        return mimg[a[9:0]];
        return 8'h00;
    endfunction

    // returns 1 when this write commits
    function automatic bit model_write(input logic [10:0] a, input logic [7:0] d);
        int idx;
        if (a >= 11'h200 && a <= 11'h203) begin
            idx = int'(a - 11'h200);
            if (idx == ms) begin
                if (idx == 0) sxl = d;
                if (idx == 1) sxh = d;
                if (idx == 2) syl = d;
                if (idx == 3) begin
                    px = {sxh, sxl};
                    py = {d, syl};
                    ms = 0;
                    return 1'b1;
                end
                ms = ms + 1;
            end else if (idx == 0) begin
                sxl = d;
                ms = 1;
            end else begin
                ms = 0;
            end
        end else if (a == 11'h204) begin
            mctrl = d[3:0];
        end else if (a[10]) begin
            mimg[a[9:0]] = d;
        end
        return 1'b0;
    endfunction

    task automatic set_addr(input logic [10:0] a);
        addr_wr = 1'b1; addr_in = a;
        @(negedge clk);
        addr_wr = 1'b0;
        mp = a;
    endtask

    task automatic wr(input logic [7:0] d);
        void'(model_write(mp, d));
        data_wr = 1'b1; wdata = d;
        @(negedge clk);
        data_wr = 1'b0;
        mp = mp + 1'b1;
    endtask

    task automatic rd(input string req);
        logic [7:0] e;
        e = model_read(mp);
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
        chk(req, {24'h0, rdata}, {24'h0, e});
        mp = mp + 1'b1;
    endtask

    task automatic vret(input string req);
        vretrace = 1'b1;
        @(negedge clk);
        vretrace = 1'b0;
        dx = px; dy = py;
        chk(req, {16'h0, cur_x}, {16'h0, dx});
        chk(req, {16'h0, cur_y}, {16'h0, dy});
    endtask

    task automatic read_pend(input string req);
        set_addr(11'h200);
        for (int k = 0; k < 4; k++) rd(req);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 1024; i++) mimg[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 x", {16'h0, cur_x}, 32'h0);
        chk("R1 y", {16'h0, cur_y}, 32'h0);
        chk("R1 ctrl", {28'h0, cur_ilace, cur_en, cur_mode}, 32'h0);
        read_pend("R1 pend");

        // R3 ordered update through auto-increment, R6 on retrace
        set_addr(11'h200);
        wr(8'h34); wr(8'h12); wr(8'hFE); wr(8'hFF);
        chk("R6 before retrace", {16'h0, cur_x}, 32'h0);
        read_pend("R3 R5 pending bytes");
        vret("R6 R3 signed coords");

        // R4 broken runs
        set_addr(11'h200); wr(8'h11); wr(8'h22);
        set_addr(11'h203); wr(8'h33);
        set_addr(11'h202); wr(8'h44); wr(8'h55);
        read_pend("R4 no commit");
        vret("R4 display kept");
        set_addr(11'h200); wr(8'h01);
        set_addr(11'h200); wr(8'h02); wr(8'h03);
        // R5 reads between bytes keep sequence; R3 other access between
        set_addr(11'h200); rd("R5 mid-run read");
        set_addr(11'h204); wr(8'h05);
        set_addr(11'h202); wr(8'h04); wr(8'h05);
        read_pend("R4 R5 restart commit");
        chk("R7 mode", {30'h0, cur_mode}, 32'h1);
        chk("R7 enable", {31'h0, cur_en}, 32'h1);
        chk("R7 interlace", {31'h0, cur_ilace}, 32'h0);

        // R6 commit and retrace in the same cycle
        set_addr(11'h200); wr(8'hAA); wr(8'hBB); wr(8'hCC);
        void'(model_write(mp, 8'hDD));
        data_wr = 1'b1; wdata = 8'hDD; vretrace = 1'b1;
        @(negedge clk);
        data_wr = 1'b0; vretrace = 1'b0; mp = mp + 1'b1;
        chk("R6 same-cycle x", {16'h0, cur_x}, 32'h0000BBAA);
        chk("R6 same-cycle y", {16'h0, cur_y}, 32'h0000DDCC);

        // R7 control readback
        set_addr(11'h204); wr(8'hFF);
        chk("R7 all set", {28'h0, cur_ilace, cur_en, cur_mode}, 32'hF);
        set_addr(11'h204); rd("R7 upper bits zero");

        // R8 image store and display port
        set_addr(11'h400); wr(8'h01); wr(8'h02); wr(8'h03); wr(8'h04);
        set_addr(11'h401); rd("R8 host read"); rd("R8 host read");
        img_raddr = 10'd3;
        @(negedge clk);
        chk("R8 display port", {24'h0, img_rdata}, 32'h04);

        // R2 strobe ignored during pointer load
        set_addr(11'h400);
        addr_wr = 1'b1; addr_in = 11'h401; data_wr = 1'b1; wdata = 8'hEE;
        @(negedge clk);
        addr_wr = 1'b0; data_wr = 1'b0; mp = 11'h401;
        rd("R2 load wins, no write at 401"); 
        set_addr(11'h400); rd("R2 no write at 400");

        // R10 write and read together
        set_addr(11'h402);
        void'(model_write(mp, 8'h9C));
        data_wr = 1'b1; data_rd = 1'b1; wdata = 8'h9C;
        @(negedge clk);
        data_wr = 1'b0; data_rd = 1'b0; mp = mp + 1'b1;
        rd("R10 single step to 403");
        set_addr(11'h402); rd("R10 write took effect");

        // R2 wrap, R9 unmapped
        set_addr(11'h7FE); wr(8'h11); wr(8'h22);
        set_addr(11'h7FE); rd("R2 pre-wrap"); rd("R2 pre-wrap");
        rd("R2 R9 wrapped to 000");
        chk("R2 wrap address", {21'h0, mp}, 32'h1);
        set_addr(11'h300); wr(8'h77);
        set_addr(11'h300); rd("R9 unmapped read");
        set_addr(11'h205); wr(8'h66);
        set_addr(11'h205); rd("R9 gap read");

        // constrained random coordinate traffic
        for (int i = 0; i < 400; i++) begin
            int r;
            int idx;
            r = int'($urandom % 10);
            if (r < 7) begin
                idx = ($urandom % 5 == 0) ? int'($urandom % 4) : ms;
                set_addr(11'h200 + 11'(idx));
                wr(8'($urandom));
            end else if (r < 9) begin
                vret("R6 R4 random retrace");
            end else begin
                read_pend("R3 R5 random pending");
            end
        end

        finish_run();
    end
endmodule